// File: doc/BRIEF.md
# Attribute-Masked Control/Status Register Bank

A bank of 32-bit registers sitting on a simple single-cycle memory-mapped bus. Every register carries its own compile-time attribute masks: bits that software cannot write, bits that software clears by writing a one, bits that a read clears, reserved bits and unimplemented bits, plus a reset value. A write merges the bus data into the register only where the bits are neither protected nor outside the access width. A read returns the register masked to the access width and then clears the clear-on-read bits it covered.

Hardware logic reports events through per-bit set inputs that are ORed into storage after the bus update. A set therefore always beats a clear in the same cycle. Three single-cycle error pulses report a reserved-bit change, a write of ones to unimplemented bits, and an access to an address that holds no register.

Top module: `csr_bank`

## Requirements
- R1: Reset (synchronous, active high) loads each register with its configured reset value and clears bus_rdata to 0; the default map resets to 0x000000A5, 0, 0, 0xC0DE0000 for registers 0 to 3.
- R2: Register i is decoded at byte address 4*i; an address with bits [1:0] non-zero or an index of N_REGS or more is undecoded, and a write there changes no register, a read there gives bus_rdata 0, and err_undec pulses in the access cycle.
- R3: On a decoded write, a bit that is not read-only, not write-one-to-clear, not reserved and lies inside the enable mask takes bus_wdata; every other bit keeps its old value.
- R4: The enable mask covers the low min(bus_size,4) bytes, so bus_size 1 enables bits [7:0], 2 enables [15:0], 3 enables [23:0], 4 or more enables all 32 bits and 0 enables none.
- R5: After the merge, each write-one-to-clear bit whose bus_wdata bit is 1 is cleared, whatever the access size; where the data bit is 0 it is unchanged.
- R6: A decoded read loads bus_rdata, valid the cycle after the strobe, with the register's pre-read contents ANDed with the enable mask, and clears the clear-on-read bits inside that mask; bus_rdata holds between reads.
- R7: err_rsvd pulses in a decoded write cycle when (old value XOR bus_wdata) has a 1 in a reserved bit; the reserved bits are still preserved.
- R8: err_unimp pulses in a decoded write cycle when bus_wdata has a 1 in an unimplemented bit.
- R9: hw_set bits (register i at hw_set[32*i+31:32*i]) are ORed into storage after the bus update in the same cycle, so a set wins over a same-cycle write-one-to-clear or clear-on-read.
- R10: When bus_wr and bus_rd are both high, only the write is performed: no clear-on-read, and bus_rdata holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_size | input | SIZE_W | Access size in bytes |
| bus_rdata | output | DATA_W | Registered read data |
| hw_set | input | N_REGS*DATA_W | Hardware per-bit set requests |
| err_rsvd | output | 1 | Reserved-bit change pulse |
| err_unimp | output | 1 | Unimplemented-bit write pulse |
| err_undec | output | 1 | Undecoded-address access pulse |

## Verification
The per-register properties speak only about cycles in which hw_set is quiet for that register, because a set may legally turn any bit on; the write-priority and clear properties further rely on the top never selecting a register for write and read at once. The stimulus keeps hw_set confined to the status fields of registers 1 and 2 and leaves it idle in most cycles, so the quiet-cycle properties are exercised often. Strobes and data are always driven to known values, with addresses drawn mostly from the decoded words and sometimes from misaligned or out-of-range bytes.

// File: rtl/csrb_pkg.sv
package csrb_pkg;
  localparam int DEF_NREGS = 4;
  localparam int DEF_DW    = 32;

  // packed order: {reg3, reg2, reg1, reg0}
  localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_RESET =
    {32'hC0DE_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_00A5};
  localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_RO =
    {32'hFFFF_0000, 32'h0000_FFFF, 32'h0000_FF00, 32'h0000_0000};
  localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_W1C =
    {32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 32'h0000_0000};
  localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_COR =
    {32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000};
  localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_RSVD =
    {32'h0000_0000, 32'h0000_0000, 32'hF000_0000, 32'hFF00_0000};
  localparam logic [DEF_NREGS-1:0][DEF_DW-1:0] DEF_UNIMP =
    {32'h0000_F000, 32'h0000_0000, 32'h0000_0000, 32'h00F0_0000};
endpackage

// File: rtl/csrb_size_mask.sv
module csrb_size_mask #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [SIZE_W-1:0] size,
  output logic [DATA_W-1:0] en
);
  localparam int BYTES = DATA_W / 8;

  // byte lane b is enabled when the access spans more than b bytes
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign en[b*8 +: 8] = {8{32'(size) > b}};
  end
endmodule

// File: rtl/csrb_decode.sv
module csrb_decode #(
  parameter int ADDR_W = 6,
  parameter int N_REGS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_REGS-1:0] sel,
  output logic              hit
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];
  assign hit = (addr[1:0] == 2'b00) && (32'(idx) < N_REGS);

  for (genvar i = 0; i < N_REGS; i++) begin : g_sel
    assign sel[i] = hit && (32'(idx) == i);
  end
endmodule

// File: rtl/csrb_cell.sv
module csrb_cell #(
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] RST_V = '0,
  parameter logic [DATA_W-1:0] RO    = '0,
  parameter logic [DATA_W-1:0] W1C   = '0,
  parameter logic [DATA_W-1:0] COR   = '0,
  parameter logic [DATA_W-1:0] RSVD  = '0,
  parameter logic [DATA_W-1:0] UNIMP = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] en,
  input  logic [DATA_W-1:0] set,
  output logic [DATA_W-1:0] q,
  output logic              rsvd_hit,
  output logic              unimp_hit
);
  logic [DATA_W-1:0] guard, merged, bus_next, nxt;

  always_comb begin
    guard    = RO | W1C | RSVD | ~en;
    merged   = (wdata & ~guard) | (q & guard);
    merged   = merged & ~(wdata & W1C);
    bus_next = q;
    if (wr_sel)      bus_next = merged;
    else if (rd_sel) bus_next = q & ~(COR & en);
    nxt = bus_next | set;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_V;
    else     q <= nxt;
  end

  assign rsvd_hit  = wr_sel && (|((q ^ wdata) & RSVD));
  assign unimp_hit = wr_sel && (|(wdata & UNIMP));

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!wr_sel && !rd_sel && set == '0) |=> $stable(q));
  p_guarded_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && set == '0) |=> (((q ^ $past(q)) & (RO | RSVD)) == '0));
  p_w1c_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && set == '0) |=> ((q & $past(wdata & W1C)) == '0));
  p_cor_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_sel && !wr_sel && set == '0) |=> ((q & COR & $past(en)) == '0));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csrb_pkg::*;
#(
  parameter int N_REGS = DEF_NREGS,
  parameter int DATA_W = DEF_DW,
  parameter int ADDR_W = 6,
  parameter int SIZE_W = 3,
  parameter logic [N_REGS-1:0][DATA_W-1:0] RESET_V = DEF_RESET,
  parameter logic [N_REGS-1:0][DATA_W-1:0] RO_M    = DEF_RO,
  parameter logic [N_REGS-1:0][DATA_W-1:0] W1C_M   = DEF_W1C,
  parameter logic [N_REGS-1:0][DATA_W-1:0] COR_M   = DEF_COR,
  parameter logic [N_REGS-1:0][DATA_W-1:0] RSVD_M  = DEF_RSVD,
  parameter logic [N_REGS-1:0][DATA_W-1:0] UNIMP_M = DEF_UNIMP
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [SIZE_W-1:0]        bus_size,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [N_REGS*DATA_W-1:0] hw_set,
  output logic                     err_rsvd,
  output logic                     err_unimp,
  output logic                     err_undec
);
  logic [N_REGS-1:0]             sel, rsvd_v, unimp_v;
  logic                          hit, rd_only;
  logic [DATA_W-1:0]             en, rd_mux;
  logic [N_REGS-1:0][DATA_W-1:0] q_arr;

  csrb_decode #(.ADDR_W(ADDR_W), .N_REGS(N_REGS)) u_dec (
    .addr(bus_addr), .sel(sel), .hit(hit));

  csrb_size_mask #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_mask (
    .size(bus_size), .en(en));

  // a write takes precedence over a read in the same cycle
  assign rd_only = bus_rd && !bus_wr;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    csrb_cell #(
      .DATA_W(DATA_W), .RST_V(RESET_V[i]), .RO(RO_M[i]), .W1C(W1C_M[i]),
      .COR(COR_M[i]), .RSVD(RSVD_M[i]), .UNIMP(UNIMP_M[i])
    ) u_cell (
      .clk(clk), .rst(rst),
      .wr_sel(sel[i] && bus_wr), .rd_sel(sel[i] && rd_only),
      .wdata(bus_wdata), .en(en), .set(hw_set[i*DATA_W +: DATA_W]),
      .q(q_arr[i]), .rsvd_hit(rsvd_v[i]), .unimp_hit(unimp_v[i]));
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < N_REGS; k++)
      if (sel[k]) rd_mux = rd_mux | q_arr[k];
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (rd_only) bus_rdata <= hit ? (rd_mux & en) : '0;
  end

  assign err_rsvd  = |rsvd_v;
  assign err_unimp = |unimp_v;
  assign err_undec = (bus_wr || bus_rd) && !hit;

  p_undec_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_only && !hit) |=> (bus_rdata == '0));
  p_sel_single_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  p_flag_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
    (err_rsvd || err_unimp) |-> (bus_wr && hit));
  p_both_strobes_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_rd) |=> $stable(bus_rdata));
endmodule

// File: tb/tb_csr_bank.sv
module tb_csr_bank;
  localparam int NR = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [5:0]   bus_addr;
  logic         bus_wr, bus_rd;
  logic [31:0]  bus_wdata;
  logic [2:0]   bus_size;
  logic [31:0]  bus_rdata;
  logic [127:0] hw_set;
  logic         err_rsvd, err_unimp, err_undec;

  csr_bank dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_size(bus_size),
    .bus_rdata(bus_rdata), .hw_set(hw_set), .err_rsvd(err_rsvd),
    .err_unimp(err_unimp), .err_undec(err_undec));

  always #10 clk = ~clk;

  localparam logic [31:0] M_RST[NR]   = '{32'h0000_00A5, 32'h0, 32'h0, 32'hC0DE_0000};
  localparam logic [31:0] M_RO[NR]    = '{32'h0, 32'h0000_FF00, 32'h0000_FFFF, 32'hFFFF_0000};
  localparam logic [31:0] M_W1C[NR]   = '{32'h0, 32'h0000_00FF, 32'h0, 32'h0};
  localparam logic [31:0] M_COR[NR]   = '{32'h0, 32'h0, 32'h0000_FFFF, 32'h0};
  localparam logic [31:0] M_RSVD[NR]  = '{32'hFF00_0000, 32'hF000_0000, 32'h0, 32'h0};
  localparam logic [31:0] M_UNIMP[NR] = '{32'h00F0_0000, 32'h0, 32'h0, 32'h0000_F000};

  logic [31:0] model[NR];
  logic [31:0] exp_rd;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] en_of(input logic [2:0] s);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (int'(s) > b) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic bit is_hit(input logic [5:0] a);
    return a[1:0] == 2'b00 && int'(a[5:2]) < NR;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check pulses, clock, check read data
  task automatic op(input bit wr, input bit rd, input logic [5:0] a,
                    input logic [31:0] wd, input logic [2:0] sz,
                    input logic [127:0] st, input string tag);
    logic [31:0] en, old, nv, guard;
    bit h;
    int i;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    bus_size = sz; hw_set = st;
    en = en_of(sz); h = is_hit(a); i = int'(a[5:2]);
    old = h ? model[i] : '0;
    #2;
    check({tag, " R2 undec"}, 32'(err_undec), 32'((wr || rd) && !h));
    check({tag, " R7 rsvd"}, 32'(err_rsvd),
          32'(wr && h && (|((old ^ wd) & M_RSVD[i % NR]))));
    check({tag, " R8 unimp"}, 32'(err_unimp),
          32'(wr && h && (|(wd & M_UNIMP[i % NR]))));
    if (h && wr) begin
      guard = M_RO[i] | M_W1C[i] | M_RSVD[i] | ~en;
      nv = ((wd & ~guard) | (old & guard)) & ~(wd & M_W1C[i]);
      model[i] = nv;
    end else if (h && rd) begin
      model[i] = old & ~(M_COR[i] & en);
    end
    if (rd && !wr) exp_rd = h ? (old & en) : '0;
    for (int k = 0; k < NR; k++) model[k] = model[k] | st[k*32 +: 32];
    @(posedge clk);
    #2;
    check({tag, " R6/R10 rdata"}, bus_rdata, exp_rd);
    bus_wr = 0; bus_rd = 0; hw_set = '0;
  endtask

  task automatic rd_chk(input int i, input string tag);
    op(0, 1, 6'(i * 4), 32'h0, 3'd4, '0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    rst = 1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    bus_size = 3'd4; hw_set = '0;
    seed_dummy = $urandom(32'd1234);
    for (int k = 0; k < NR; k++) model[k] = M_RST[k];
    exp_rd = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 rdata after reset", bus_rdata, 32'h0);
    @(negedge clk); rst = 0;
    for (int k = 0; k < NR; k++) rd_chk(k, "R1 reset value");

    // R3/R7/R8: full write to reg0 touches reserved and unimplemented bits
    op(1, 0, 6'd0, 32'hFFFF_FFFF, 3'd4, '0, "R3 full write");
    rd_chk(0, "R3 readback");
    // R4: byte and halfword writes, size 0 writes nothing
    op(1, 0, 6'd0, 32'h0012_3456, 3'd1, '0, "R4 byte write");
    op(1, 0, 6'd0, 32'h0000_0000, 3'd0, '0, "R4 size0 write");
    rd_chk(0, "R4 readback");
    op(1, 0, 6'd12, 32'h1234_ABCD, 3'd2, '0, "R4 half write");
    op(0, 1, 6'd12, 32'h0, 3'd3, '0, "R4 three-byte read");
    // R5: W1C with upper data ignored by size but W1C still acts
    op(0, 0, 6'd0, 32'h0, 3'd4, {64'h0, 32'h0000_00FF, 32'h0}, "R9 set status");
    op(1, 0, 6'd4, 32'h0000_000F, 3'd0, '0, "R5 w1c size0");
    rd_chk(1, "R5 readback");
    // R9: set wins over same-cycle W1C
    op(1, 0, 6'd4, 32'h0000_00F0, 3'd4, {64'h0, 32'h0000_0080, 32'h0}, "R9 set vs w1c");
    rd_chk(1, "R9 readback");
    // R6: clear-on-read limited to enable
    op(0, 0, 6'd0, 32'h0, 3'd4, {32'h0, 32'h0000_FFFF, 64'h0}, "R9 set event");
    op(0, 1, 6'd8, 32'h0, 3'd1, '0, "R6 byte cor read");
    rd_chk(2, "R6 remaining");
    rd_chk(2, "R6 cleared");
    // R9: set wins over same-cycle clear-on-read
    op(0, 1, 6'd8, 32'h0, 3'd4, {32'h0, 32'h0000_0001, 64'h0}, "R9 set vs cor");
    rd_chk(2, "R9 cor readback");
    // R2: undecoded and misaligned accesses
    op(1, 0, 6'd16, 32'hFFFF_FFFF, 3'd4, '0, "R2 oob write");
    op(0, 1, 6'd20, 32'h0, 3'd4, '0, "R2 oob read");
    op(1, 0, 6'd1, 32'hFFFF_FFFF, 3'd4, '0, "R2 misaligned write");
    rd_chk(0, "R2 reg0 untouched");
    // R10: both strobes
    op(1, 1, 6'd12, 32'h0000_5555, 3'd4, '0, "R10 both strobes");
    rd_chk(3, "R10 write applied");

    for (int n = 0; n < 600; n++) begin
      logic [5:0]   a;
      logic [127:0] st;
      int r = int'($urandom_range(0, 9));
      a = (r < 8) ? 6'(($urandom_range(0, NR - 1)) * 4) : 6'($urandom_range(0, 63));
      st = '0;
      if ($urandom_range(0, 3) == 0)
        st = {32'h0, 32'($urandom) & 32'h0000_FFFF, 32'($urandom) & 32'h0000_FFFF, 32'h0};
      op(1'($urandom), 1'($urandom), a, $urandom, 3'($urandom_range(0, 5)), st, "R3 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule